// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one parallel data word into an asynchronous serial frame. The frame format is chosen at run time on configuration inputs: the data length (5 to 8 bits), an optional ninth bit that carries either hardware parity or a bit supplied by software, and the stop interval. A word is offered with a valid/ready handshake. The block accepts it only when the line is idle, then drives a low start bit, the data bits least significant first, the optional ninth bit and a high stop interval.

Timing is counted from a one-clock-wide oversample tick produced by an external baud generator. Each bit lasts 16 ticks. A long stop lasts 24 ticks (one and a half bits) when the data length is 5, and 32 ticks (two bits) otherwise. The configuration and the data are captured when the word is accepted, so later changes on those inputs do not alter a frame that is already on the line. Baud generation, FIFOs and interrupts are provided elsewhere.

Top module: `uart_frame_tx`

## Requirements
- R1: While idle, and out of reset, txOut is 1. After a word is accepted, txOut is 0 for exactly 16 tick16 pulses (the start bit).
- R2: cfgLen selects the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. The bits inData[0] up to inData[len-1] follow the start bit in that order, each for 16 ticks. Higher bits of inData are not sent.
- R3: With cfgParityEn=1, one parity bit of 16 ticks follows the data. cfgParityMode 0 is even parity, so the ones in the sent data and the parity bit together are even. 1 is odd parity, 2 always sends 1 and 3 always sends 0.
- R4: With cfgExtraEn=1 and cfgParityEn=0, extraBit is sent for 16 ticks after the data. With cfgParityEn=1, cfgExtraEn and extraBit have no effect on the frame.
- R5: With cfgParityEn=0 and cfgExtraEn=0, the stop interval follows the last data bit directly.
- R6: With cfgLongStop=0, the stop interval is 16 ticks of txOut=1.
- R7: With cfgLongStop=1, the stop interval is 24 ticks when cfgLen=0 and 32 ticks otherwise.
- R8: inReady equals the inverse of busy. busy rises in the cycle after a word is accepted (inValid=1 while inReady=1). It falls, and inReady rises, in the cycle after the clock edge that sees the last stop tick. inValid has no effect while busy=1.
- R9: inData and all configuration inputs are sampled at acceptance. Changing them during a frame has no effect on that frame.
- R10: Cycles without a tick16 pulse neither advance nor change the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Oversample tick, 16 per bit time |
| inData | input | 8 | Word to send |
| inValid | input | 1 | Word offered |
| inReady | output | 1 | Block can accept a word |
| cfgLen | input | 2 | Data length code (5 + code bits) |
| cfgParityEn | input | 1 | Append a parity bit |
| cfgParityMode | input | 2 | 0 even, 1 odd, 2 mark, 3 space |
| cfgExtraEn | input | 1 | Append extraBit when parity is off |
| extraBit | input | 1 | Value of the extra bit |
| cfgLongStop | input | 1 | Select the long stop interval |
| txOut | output | 1 | Serial line, idles high |
| busy | output | 1 | A frame is in progress |

## Verification
txOut changes in the cycle after the edge that accepts a word, and in the cycle after the edge that sees the last tick of each bit. busy and inReady change one cycle after the accepting edge and one cycle after the final stop tick. The bench keeps a behavioural model that rebuilds each frame as a queue of levels and tick durations at the same edge the design samples. It compares all three outputs 2 ns after every rising edge, once every register has settled. Tick spacing of 1, 2 and 3 cycles, together with inputs scrambled during each frame, shows that timing follows only the ticks and only the values captured at acceptance.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;
  typedef enum logic [1:0] {
    PAR_EVEN  = 2'd0,
    PAR_ODD   = 2'd1,
    PAR_MARK  = 2'd2,
    PAR_SPACE = 2'd3
  } parMode_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_DATA, PH_NINTH, PH_STOP
  } phase_t;

  typedef struct packed {
    logic load;
    logic shift;
    logic driveLow;
    logic driveData;
    logic driveNinth;
  } txStrobe_t;
endpackage

// File: rtl/frame_tx_ctrl.sv
module frame_tx_ctrl
  import frame_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16,
  parameter int LEN_W  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick16,
  input  logic             inValid,
  input  logic [LEN_W-1:0] cfgLen,
  input  logic             cfgNinthEn,
  input  logic             cfgLongStop,
  output txStrobe_t        strobe,
  output logic             busy,
  output logic             inReady
);
  localparam int CNT_W   = $clog2(2 * OSR);
  localparam int BIT_W   = $clog2(DATA_W);
  localparam int MIN_LEN = DATA_W - (1 << LEN_W) + 1;
  localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] LONG_MIN  = CNT_W'((OSR * 3) / 2 - 1);
  localparam logic [CNT_W-1:0] LONG_FULL = CNT_W'(2 * OSR - 1);

  phase_t           phase;
  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] stopLast;
  logic [BIT_W-1:0] bitCnt;
  logic [BIT_W-1:0] lastBit;
  logic             ninthOn;
  logic             accept;
  logic             atEnd;

  assign accept = inValid && (phase == PH_IDLE);
  assign atEnd  = tickCnt == ((phase == PH_STOP) ? stopLast : BIT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      tickCnt  <= '0;
      bitCnt   <= '0;
      lastBit  <= '0;
      ninthOn  <= 1'b0;
      stopLast <= BIT_LAST;
    end else if (accept) begin
      phase    <= PH_START;
      tickCnt  <= '0;
      bitCnt   <= '0;
      lastBit  <= BIT_W'(cfgLen) + BIT_W'(MIN_LEN - 1);
      ninthOn  <= cfgNinthEn;
      stopLast <= !cfgLongStop ? BIT_LAST :
                  (cfgLen == '0) ? LONG_MIN : LONG_FULL;
    end else if (tick16 && phase != PH_IDLE) begin
      if (!atEnd) begin
        tickCnt <= tickCnt + 1'b1;
      end else begin
        tickCnt <= '0;
        unique case (phase)
          PH_START: begin
            phase  <= PH_DATA;
            bitCnt <= '0;
          end
          PH_DATA: begin
            if (bitCnt == lastBit) phase <= ninthOn ? PH_NINTH : PH_STOP;
            else bitCnt <= bitCnt + 1'b1;
          end
          PH_NINTH: phase <= PH_STOP;
          PH_STOP:  phase <= PH_IDLE;
          default:  phase <= PH_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.load       = accept;
    strobe.shift      = tick16 && atEnd && (phase == PH_DATA);
    strobe.driveLow   = phase == PH_START;
    strobe.driveData  = phase == PH_DATA;
    strobe.driveNinth = phase == PH_NINTH;
  end

  assign busy    = phase != PH_IDLE;
  assign inReady = phase == PH_IDLE;

  a_r9_cfg_held: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(lastBit) && $stable(ninthOn) && $stable(stopLast));
  a_r10_no_tick_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !tick16) |=> $stable(phase) && $stable(tickCnt));
  a_r1_bit_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    (busy && phase != PH_STOP) |-> tickCnt <= BIT_LAST);
  a_r2_data_index_bound: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DATA) |-> bitCnt <= lastBit);
endmodule

// File: rtl/frame_tx_dpath.sv
module frame_tx_dpath
  import frame_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] inData,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic              cfgParityEn,
  input  logic [1:0]        cfgParityMode,
  input  logic              extraBit,
  output logic              txOut
);
  localparam int MIN_LEN = DATA_W - (1 << LEN_W) + 1;

  logic [DATA_W-1:0] masked;
  logic [DATA_W-1:0] shiftReg;
  logic              ninthReg;
  logic              ninthNext;
  logic              onesOdd;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign masked[i] = inData[i] && (i < (int'(cfgLen) + MIN_LEN));
  end

  assign onesOdd = ^masked;

  always_comb begin
    if (!cfgParityEn) begin
      ninthNext = extraBit;
    end else begin
      unique case (parMode_t'(cfgParityMode))
        PAR_EVEN:  ninthNext = onesOdd;
        PAR_ODD:   ninthNext = !onesOdd;
        PAR_MARK:  ninthNext = 1'b1;
        PAR_SPACE: ninthNext = 1'b0;
        default:   ninthNext = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      ninthReg <= 1'b0;
    end else if (strobe.load) begin
      shiftReg <= masked;
      ninthReg <= ninthNext;
    end else if (strobe.shift) begin
      shiftReg <= shiftReg >> 1;
    end
  end

  always_comb begin
    if (strobe.driveLow)        txOut = 1'b0;
    else if (strobe.driveData)  txOut = shiftReg[0];
    else if (strobe.driveNinth) txOut = ninthReg;
    else                        txOut = 1'b1;
  end

  a_r2_shift_fills_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |=> !shiftReg[DATA_W-1]);
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import frame_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick16,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic              cfgParityEn,
  input  logic [1:0]        cfgParityMode,
  input  logic              cfgExtraEn,
  input  logic              extraBit,
  input  logic              cfgLongStop,
  output logic              txOut,
  output logic              busy
);
  txStrobe_t strobe;

  frame_tx_ctrl #(.DATA_W(DATA_W), .OSR(OSR), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick16(tick16), .inValid(inValid),
    .cfgLen(cfgLen), .cfgNinthEn(cfgParityEn || cfgExtraEn),
    .cfgLongStop(cfgLongStop), .strobe(strobe), .busy(busy), .inReady(inReady)
  );

  frame_tx_dpath #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData), .cfgLen(cfgLen),
    .cfgParityEn(cfgParityEn), .cfgParityMode(cfgParityMode),
    .extraBit(extraBit), .txOut(txOut)
  );

  a_r1_start_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !txOut && busy);
  a_r8_idle_line_high: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> txOut);
  a_r10_line_needs_tick: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !tick16) |=> $stable(txOut));
endmodule

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick16 = 1'b0;
  logic [7:0] inData = 8'h00;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [1:0] cfgLen = 2'd3;
  logic       cfgParityEn = 1'b0;
  logic [1:0] cfgParityMode = 2'd0;
  logic       cfgExtraEn = 1'b0;
  logic       extraBit = 1'b0;
  logic       cfgLongStop = 1'b0;
  logic       txOut;
  logic       busy;

  always #2.5 clk = ~clk;

  uart_frame_tx dut (
    .clk(clk), .rstN(rstN), .tick16(tick16), .inData(inData), .inValid(inValid),
    .inReady(inReady), .cfgLen(cfgLen), .cfgParityEn(cfgParityEn),
    .cfgParityMode(cfgParityMode), .cfgExtraEn(cfgExtraEn), .extraBit(extraBit),
    .cfgLongStop(cfgLongStop), .txOut(txOut), .busy(busy)
  );

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int tickDiv = 1;
  int tickPhase = 0;
  bit done = 0;

  // Behavioural reference: a frame is a queue of (level, ticks, requirement)
  int    lvlQ[$];
  int    durQ[$];
  string reqQ[$];
  bit    mBusy = 0;
  int    mLevel = 1;
  int    mRem = 0;
  string mReq = "R1";

  task automatic buildFrame();
    int len;
    int ones;
    int ninth;
    bit hasNinth;
    len = int'(cfgLen) + 5;
    ones = 0;
    lvlQ.push_back(0); durQ.push_back(16); reqQ.push_back("R1");
    for (int i = 0; i < len; i++) begin
      lvlQ.push_back(int'(inData[i])); durQ.push_back(16); reqQ.push_back("R2");
      ones += int'(inData[i]);
    end
    hasNinth = cfgParityEn || cfgExtraEn;
    if (cfgParityEn) begin
      case (cfgParityMode)
        2'd0: ninth = ones % 2;
        2'd1: ninth = 1 - (ones % 2);
        2'd2: ninth = 1;
        default: ninth = 0;
      endcase
      lvlQ.push_back(ninth); durQ.push_back(16); reqQ.push_back("R3/R4");
    end else if (hasNinth) begin
      lvlQ.push_back(int'(extraBit)); durQ.push_back(16); reqQ.push_back("R4");
    end
    lvlQ.push_back(1);
    durQ.push_back(!cfgLongStop ? 16 : (cfgLen == 2'd0 ? 24 : 32));
    reqQ.push_back(!cfgLongStop ? (hasNinth ? "R6" : "R5/R6") : "R7");
  endtask

  task automatic popSeg();
    mLevel = lvlQ.pop_front();
    mRem = durQ.pop_front();
    mReq = reqQ.pop_front();
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d",
               req, what, cycles, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mLevel = 1; mReq = "R1";
      lvlQ.delete(); durQ.delete(); reqQ.delete();
    end else if (!mBusy && inValid) begin
      buildFrame();
      popSeg();
      mBusy = 1;
    end else if (mBusy && tick16) begin
      mRem--;
      if (mRem == 0) begin
        if (lvlQ.size() == 0) begin
          mBusy = 0; mLevel = 1; mReq = "R1";
        end else begin
          popSeg();
        end
      end
    end
    #2;
    cycles++;
    check(txOut === mLevel[0], mReq, "txOut", int'(txOut), mLevel);
    check(busy === mBusy, "R8", "busy", int'(busy), int'(mBusy));
    check(inReady === !mBusy, "R8", "inReady", int'(inReady), int'(!mBusy));
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired: actual %0d cycles expected under 150000", cycles);
      finishRun();
    end
  end

  // tick generator: one pulse every tickDiv cycles
  always @(negedge clk) begin
    tickPhase = (tickPhase + 1) % tickDiv;
    tick16 <= (tickPhase == 0);
  end

  // Offer a word, wait for acceptance, scramble all inputs (R9), wait for idle.
  task automatic sendFrame(input logic [7:0] d, input logic [1:0] len, input bit pEn,
                           input logic [1:0] pMode, input bit xEn, input bit xBit,
                           input bit longStop, input bit keepValid);
    @(negedge clk);
    inData = d; cfgLen = len; cfgParityEn = pEn; cfgParityMode = pMode;
    cfgExtraEn = xEn; extraBit = xBit; cfgLongStop = longStop; inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    // R9: change every sampled input during the frame; R8: inValid while busy
    inData = ~d; cfgLen = ~len; cfgParityEn = !pEn; cfgParityMode = ~pMode;
    cfgExtraEn = !xEn; extraBit = !xBit; cfgLongStop = !longStop;
    inValid = keepValid;
    if (!keepValid) while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R1, R2, R5, R6: 8-bit, no ninth bit, short stop
    tickDiv = 1;
    sendFrame(8'hA5, 2'd3, 0, 2'd0, 0, 0, 0, 0);
    // R2, R3, R7: 5-bit, even parity, 1.5-bit stop; high bits must be dropped
    sendFrame(8'hF3, 2'd0, 1, 2'd0, 0, 0, 1, 0);
    // R3, R7: 6-bit odd parity, 2-bit stop
    tickDiv = 2;
    sendFrame(8'h2D, 2'd1, 1, 2'd1, 0, 0, 1, 0);
    // R3: 7-bit mark, 8-bit space
    sendFrame(8'h00, 2'd2, 1, 2'd2, 0, 0, 0, 0);
    sendFrame(8'hFF, 2'd3, 1, 2'd3, 0, 0, 0, 0);
    // R4: extra bit alone, both values
    tickDiv = 3;
    sendFrame(8'h5A, 2'd3, 0, 2'd0, 1, 1, 0, 0);
    sendFrame(8'h0F, 2'd1, 0, 2'd0, 1, 0, 1, 0);
    // R4: extra enabled with parity is ignored (even parity of 3 ones -> 1, extraBit 0)
    sendFrame(8'h07, 2'd2, 1, 2'd0, 1, 0, 0, 0);
    sendFrame(8'h06, 2'd0, 1, 2'd1, 1, 1, 1, 0);
    // R8, R10: back-to-back with inValid held high through the frame
    tickDiv = 1;
    sendFrame(8'h81, 2'd3, 0, 2'd0, 0, 0, 0, 1);
    while (busy) @(negedge clk);
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
    while (busy) @(negedge clk);
    // R7: 5-bit long stop again with even parity of zero ones
    tickDiv = 2;
    sendFrame(8'hE0, 2'd0, 1, 2'd0, 0, 0, 1, 0);
    repeat (10) @(negedge clk);
    if (!done) begin
      done = 1;
      finishRun();
    end
  end
endmodule